// File: doc/BRIEF.md
# Block Zero and Tag Engine

This engine clears one naturally aligned block of memory and, in the same pass, stamps a four-bit allocation tag on every 16-byte tag granule in that block. A request carries a 64-bit byte address with no alignment constraint. Any byte address inside a block selects the whole block. The block size is a build-time power of two. It is published on a read-only identification output as the log2 of the number of 4-byte words it holds.

After accepting a request, the engine aligns the address down to the block base and checks the memory-type attribute that comes with the request. It then streams one 16-byte write beat per accepted cycle in ascending address order. Each beat carries all-zero data and the tag taken from the request address. A Device memory type ends the operation with an alignment fault and issues no writes. An error response on any beat stops the stream and reports a data abort that carries the address of the failing beat. Normal memory is handled the same way whatever its cacheability. Completion, with or without a fault, is marked by a one-cycle done pulse.

The controller has four states. `S_IDLE` accepts a request and moves to `S_CHECK`. `S_CHECK` moves to `S_DONE` for Device memory, and to `S_WRITE` otherwise. `S_WRITE` holds its beat while ready is low. It moves to `S_DONE` on an error response or on the last beat, and otherwise stays in `S_WRITE`. `S_DONE` raises done for one cycle and returns to `S_IDLE`.

Top module: `bzt_engine`

## Requirements
- R1: `size_id` always equals the parameter `SIZE_FIELD`. The block size is N = 4 << `SIZE_FIELD` bytes, for field values 4 to 9 (64 to 2048 bytes).
- R2: `req_ready` is high only in the idle state. A request is taken only when `req_valid` and `req_ready` are both high. A `req_valid` raised while the engine is busy starts nothing and does not alter the operation in progress.
- R3: The block base is the request address with its low log2(N) bits cleared. Two addresses in the same block produce identical beat addresses.
- R4: For Normal memory, exactly N/16 beats are issued at addresses base + 16*i for i = 0 upward. A beat advances only in a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_addr` holds.
- R5: `wr_data` is all zero on every beat.
- R6: `wr_tag` equals request address bits [59:56] on every beat of the operation.
- R7: When `req_device` is high at acceptance, no beat is issued. Two cycles after acceptance, done pulses with `fault_code` = 2'b01 (alignment fault), and `fault_addr` equals the request address.
- R8: When `wr_err` is high on an accepted beat, no further beat follows. Done then pulses with `fault_code` = 2'b10 (data abort), and `fault_addr` equals that beat's address.
- R9: `done` is high for exactly one cycle per accepted request. On success `fault_code` = 2'b00 and `fault_addr` = 0. `fault_code` and `fault_addr` read zero whenever done is low.
- R10: The cache-maintenance syndrome bit `fault_cm` is low on every completion, including both fault kinds.
- R11: After reset the engine is idle: `req_ready` = 1, `wr_valid` = 0, `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_addr | input | 64 | Byte address selecting the block and the tag |
| req_device | input | 1 | Memory type of the block is Device |
| size_id | output | 4 | Read-only block size field, log2 of 4-byte words |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Downstream accepts the beat |
| wr_addr | output | 64 | 16-byte aligned beat address |
| wr_data | output | 128 | Beat data, always zero |
| wr_tag | output | 4 | Allocation tag for the beat's granule |
| wr_err | input | 1 | Error response for the beat accepted this cycle |
| done | output | 1 | One-cycle completion pulse |
| fault_code | output | 2 | 00 none, 01 alignment, 10 data abort; valid with done |
| fault_addr | output | 64 | Faulting address; valid with done |
| fault_cm | output | 1 | Cache-maintenance syndrome bit |

## Verification
The bench builds the engine with `SIZE_FIELD` = 5, a 128-byte block of eight beats. That size is big enough to place an error on the first, a middle and the last beat, and to stall on several beats while `wr_ready` is low. It is also small enough to place request addresses at the first byte, the last byte and middle bytes of a block, including the block at the top of the address space. Tags differ from one vector to the next, so a tag left over from an earlier request would be caught.

// File: rtl/bzt_pkg.sv
package bzt_pkg;
    localparam int ADDR_W    = 64;
    localparam int BEAT_LOG2 = 4;
    localparam int BEAT_BITS = 8 << BEAT_LOG2;
    localparam int TAG_LO    = 56;
    localparam int TAG_W     = 4;
    localparam int SZ_W      = 4;
    localparam int FIELD_MIN = 4;
    localparam int FIELD_MAX = 9;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CHECK = 2'd1,
        S_WRITE = 2'd2,
        S_DONE  = 2'd3
    } state_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_ALIGN = 2'b01,
        FLT_ABORT = 2'b10
    } fault_e;

    function automatic logic [ADDR_W-1:0] blk_mask(input int log2_bytes);
        blk_mask = ~((ADDR_W'(1) << log2_bytes) - ADDR_W'(1));
    endfunction
endpackage

// File: rtl/bzt_align.sv
module bzt_align
    import bzt_pkg::*;
#(
    parameter int BLK_LOG2 = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] base,
    output logic [TAG_W-1:0]  tag
);
    localparam logic [ADDR_W-1:0] MASK = blk_mask(BLK_LOG2);

    always_comb begin
        base = addr & MASK;
        tag  = addr[TAG_LO +: TAG_W];
    end
endmodule

// File: rtl/bzt_beat_seq.sv
module bzt_beat_seq
    import bzt_pkg::*;
#(
    parameter int BLK_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              step,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              last
);
    localparam int CNT_W = BLK_LOG2 - BEAT_LOG2;
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= base_in;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        beat_addr = base_q | (ADDR_W'(cnt_q) << BEAT_LOG2);
        last      = (cnt_q == CNT_LAST);
    end
endmodule

// File: rtl/bzt_engine.sv
module bzt_engine
    import bzt_pkg::*;
#(
    parameter int SIZE_FIELD = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_device,
    output logic [SZ_W-1:0]      size_id,
    output logic                 wr_valid,
    input  logic                 wr_ready,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [BEAT_BITS-1:0] wr_data,
    output logic [TAG_W-1:0]     wr_tag,
    input  logic                 wr_err,
    output logic                 done,
    output logic [1:0]           fault_code,
    output logic [ADDR_W-1:0]    fault_addr,
    output logic                 fault_cm
);
    localparam int BLK_LOG2 = SIZE_FIELD + 2;

    generate
        if (SIZE_FIELD < FIELD_MIN || SIZE_FIELD > FIELD_MAX) begin : g_bad_size
            $error("SIZE_FIELD out of range");
        end
    endgenerate

    state_e            state_q, state_d;
    logic              accept, beat_go, beat_ok;
    logic [ADDR_W-1:0] base_w, beat_addr;
    logic [TAG_W-1:0]  tag_w, tag_q;
    logic              last_w;
    logic              dev_q;
    logic [ADDR_W-1:0] addr_q;
    fault_e            flt_q;
    logic [ADDR_W-1:0] flt_addr_q;

    assign accept  = req_valid && (state_q == S_IDLE);
    assign beat_go = (state_q == S_WRITE) && wr_ready;
    assign beat_ok = beat_go && !wr_err;

    bzt_align #(.BLK_LOG2(BLK_LOG2)) u_align (
        .addr (req_addr),
        .base (base_w),
        .tag  (tag_w)
    );

    bzt_beat_seq #(.BLK_LOG2(BLK_LOG2)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .base_in   (base_w),
        .step      (beat_ok),
        .beat_addr (beat_addr),
        .last      (last_w)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_CHECK;
            S_CHECK: state_d = dev_q ? S_DONE : S_WRITE;
            S_WRITE: if (wr_ready && (wr_err || last_w)) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
        endcase
    end

    // request latch and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q      <= '0;
            dev_q      <= 1'b0;
            addr_q     <= '0;
            flt_q      <= FLT_NONE;
            flt_addr_q <= '0;
        end else if (accept) begin
            tag_q      <= tag_w;
            dev_q      <= req_device;
            addr_q     <= req_addr;
            flt_q      <= FLT_NONE;
            flt_addr_q <= '0;
        end else if (state_q == S_CHECK && dev_q) begin
            flt_q      <= FLT_ALIGN;
            flt_addr_q <= addr_q;
        end else if (beat_go && wr_err) begin
            flt_q      <= FLT_ABORT;
            flt_addr_q <= beat_addr;
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == S_IDLE);
        wr_valid   = (state_q == S_WRITE);
        done       = (state_q == S_DONE);
        wr_addr    = beat_addr;
        wr_tag     = tag_q;
        wr_data    = '0;
        size_id    = SZ_W'(SIZE_FIELD);
        fault_code = done ? flt_q : FLT_NONE;
        fault_addr = done ? flt_addr_q : '0;
        fault_cm   = 1'b0;
    end
endmodule

// File: rtl/bzt_engine_chk.sv
module bzt_engine_chk
    import bzt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_device,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [TAG_W-1:0]  wr_tag,
    input logic              wr_err,
    input logic              done,
    input logic [1:0]        fault_code
);
    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !req_ready);

    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr));

    p_beat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && !wr_err |=> (!wr_valid || wr_addr == $past(wr_addr) + 64'd16));

    p_tag_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && $past(wr_valid) |-> $stable(wr_tag));

    p_device_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_device |=> !wr_valid ##1 (done && fault_code == 2'b01));

    p_err_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && wr_err |=> !wr_valid && done && fault_code == 2'b10);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind bzt_engine bzt_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_device (req_device),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_tag     (wr_tag),
    .wr_err     (wr_err),
    .done       (done),
    .fault_code (fault_code)
);

// File: tb/test_bzt_engine.sv
module test_bzt_engine;
    localparam int SF    = 5;
    localparam int BLK   = 4 << SF;
    localparam int BEATS = BLK / 16;
    localparam logic [63:0] MASK = ~(64'(BLK) - 64'd1);

    typedef struct packed {
        logic [63:0] addr;
        logic        dev;
        logic [3:0]  err;   // beat index that errors, 4'hF = none
        logic        stall;
        logic        poke;  // raise req_valid mid-run
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{64'h0A00_0000_1234_5677, 1'b0, 4'hF, 1'b0, 1'b1},
        '{64'h3500_0000_1234_5600, 1'b0, 4'hF, 1'b1, 1'b0},
        '{64'hF700_0000_0000_007F, 1'b0, 4'hF, 1'b0, 1'b0},
        '{64'h0C00_0000_0000_1001, 1'b1, 4'hF, 1'b0, 1'b0},
        '{64'h0200_0000_8000_0045, 1'b0, 4'h0, 1'b0, 1'b0},
        '{64'h0900_0000_8000_00FF, 1'b0, 4'h7, 1'b1, 1'b0},
        '{64'h0100_FFFF_FFFF_FFFF, 1'b0, 4'h3, 1'b0, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [63:0]  req_addr = '0;
    logic         req_device = 1'b0;
    logic [3:0]   size_id;
    logic         wr_valid;
    logic         wr_ready = 1'b0;
    logic [63:0]  wr_addr;
    logic [127:0] wr_data;
    logic [3:0]   wr_tag;
    logic         wr_err = 1'b0;
    logic         done;
    logic [1:0]   fault_code;
    logic [63:0]  fault_addr;
    logic         fault_cm;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    bzt_engine #(.SIZE_FIELD(SF)) i_bzt_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_device(req_device), .size_id(size_id),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_tag(wr_tag), .wr_err(wr_err), .done(done),
        .fault_code(fault_code), .fault_addr(fault_addr), .fault_cm(fault_cm)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_vec(input vec_t v, output logic [63:0] first_addr);
        logic [63:0] base, exp_addr;
        int nb, stall_cyc, wait_cyc;
        bit seen_done, err_sent;
        base = v.addr & MASK;
        nb = 0; stall_cyc = 0; wait_cyc = 0;
        seen_done = 0; err_sent = 0;
        first_addr = '1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 idle ready", 128'(req_ready), 128'd1);
        req_valid = 1'b1; req_addr = v.addr; req_device = v.dev;
        @(negedge clk);
        req_valid = 1'b0; req_device = 1'b0;
        while (!seen_done && wait_cyc < 200) begin
            wait_cyc++;
            wr_err = 1'b0;
            if (v.poke && nb == 2) begin
                req_valid = 1'b1;
                req_addr = 64'h0500_0000_0000_0000;
            end else begin
                req_valid = 1'b0;
            end
            if (v.dev) chk(wr_valid == 1'b0, "R7 no beat on device", 128'(wr_valid), 128'd0);
            if (done) begin
                seen_done = 1;
                req_valid = 1'b0;
                wr_ready = 1'b0;
                if (v.dev) begin
                    chk(fault_code == 2'b01, "R7 align code", 128'(fault_code), 128'd1);
                    chk(fault_addr == v.addr, "R7 fault addr", 128'(fault_addr), 128'(v.addr));
                    chk(wait_cyc == 2, "R7 done timing", 128'(wait_cyc), 128'd2);
                end else if (v.err != 4'hF) begin
                    chk(fault_code == 2'b10, "R8 abort code", 128'(fault_code), 128'd2);
                    chk(fault_addr == base + 64'(v.err) * 16, "R8 fault addr",
                        128'(fault_addr), 128'(base + 64'(v.err) * 16));
                    chk(nb == int'(v.err) + 1, "R8 beats before stop", 128'(nb), 128'(v.err + 1));
                end else begin
                    chk(fault_code == 2'b00, "R9 ok code", 128'(fault_code), 128'd0);
                    chk(fault_addr == 64'd0, "R9 ok addr", 128'(fault_addr), 128'd0);
                    chk(nb == BEATS, "R4 beat count", 128'(nb), 128'(BEATS));
                end
                chk(fault_cm == 1'b0, "R10 cm clear", 128'(fault_cm), 128'd0);
            end else begin
                chk(fault_code == 2'b00 && fault_addr == 64'd0, "R9 quiet fault outputs",
                    128'(fault_addr), 128'd0);
                if (wr_valid) begin
                    exp_addr = base + 64'(nb) * 16;
                    if (nb == 0) first_addr = wr_addr;
                    chk(wr_addr == exp_addr, "R3 R4 beat addr", 128'(wr_addr), 128'(exp_addr));
                    chk(wr_data == '0, "R5 zero data", wr_data, 128'd0);
                    chk(wr_tag == v.addr[59:56], "R6 tag", 128'(wr_tag), 128'(v.addr[59:56]));
                    chk(!err_sent, "R8 beat after error", 128'(nb), 128'(v.err));
                    if (v.stall && (stall_cyc % 3 == 1)) wr_ready = 1'b0;
                    else wr_ready = 1'b1;
                    stall_cyc++;
                    if (wr_ready) begin
                        if (nb == int'(v.err)) begin
                            wr_err = 1'b1;
                            err_sent = 1;
                        end
                        nb++;
                    end
                end else begin
                    wr_ready = 1'b0;
                end
            end
            @(negedge clk);
        end
        wr_err = 1'b0;
        req_valid = 1'b0;
        chk(seen_done, "R9 done seen", 128'(seen_done), 128'd1);
        chk(done == 1'b0, "R9 done one cycle", 128'(done), 128'd0);
        for (int i = 0; i < 3; i++) begin
            chk(wr_valid == 1'b0 && req_ready == 1'b1, "R2 no stray request",
                128'(wr_valid), 128'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        logic [63:0] fa, fb;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R11 reset ready", 128'(req_ready), 128'd1);
        chk(wr_valid == 1'b0, "R11 reset wr_valid", 128'(wr_valid), 128'd0);
        chk(done == 1'b0, "R11 reset done", 128'(done), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(size_id == 4'(SF), "R1 size field", 128'(size_id), 128'(SF));

        for (int k = 0; k < NV; k++) begin
            run_vec(VECS[k], fa);
        end

        // R3: first and last byte of one block give the same first beat
        run_vec('{64'h0600_0000_0004_0000, 1'b0, 4'hF, 1'b0, 1'b0}, fa);
        run_vec('{64'h0600_0000_0004_007F, 1'b0, 4'hF, 1'b0, 1'b0}, fb);
        chk(fa == fb && fa == 64'h0600_0000_0004_0000, "R3 same block", 128'(fb), 128'(fa));

        // R11: reset during a run returns to idle
        @(negedge clk);
        req_valid = 1'b1; req_addr = 64'h0; req_device = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(wr_valid == 1'b0 && req_ready == 1'b1, "R11 mid-run reset", 128'(wr_valid), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule